// File: doc/BRIEF.md
# Interrupt acknowledge vector acquisition

This block runs the vector-fetch phase of an interrupt acknowledge cycle on a 68k-style asynchronous processor bus. An acknowledge request arrives with the interrupt level being serviced. The block raises an address strobe and, on every clock edge while the strobe is high, it looks at the responses from the bus. A responder can complete the cycle with a data-strobe acknowledge that carries an 8-bit vector, or with an autovector request. A bus error aborts the cycle, and halt can be combined with the other responses.

Exactly one result comes back for each bus cycle. It is either a one-cycle done pulse with the final vector number, or a one-cycle retry pulse. A bus error yields the spurious vector 24. A bus error together with halt makes the block run the acknowledge again. An internal timeout monitor counts strobe cycles from the moment the strobe goes high. It raises an internal bus error when nobody answers, so a silent bus also ends on a vector or a retry.

Top module: `intack_vector_fetch`

## Requirements
- R1: After reset, strobe_o, done_o and retry_o are low and vector_o is 0.
- R2: When ack_req is high in idle with a nonzero ack_level (1 to 7), strobe_o goes high on the next cycle. A request with level 0 is ignored. A request made while a cycle is in progress is ignored and does not change the level of that cycle.
- R3: A data-strobe acknowledge (dtack_i high) sampled while strobe_o is high, with no bus error and no timeout, gives a done pulse in the next cycle. vector_o then carries data_i as sampled on that edge. Halt asserted with the acknowledge does not change this result.
- R4: An autovector request (avec_i high) with no acknowledge, no bus error and no timeout gives a done pulse with vector 24 plus the latched level. The data bus is not used. When dtack_i and avec_i are sampled together, the data-strobe acknowledge wins.
- R5: An external bus error without halt gives a done pulse with the spurious vector 24. This holds even when an acknowledge or an autovector request arrives on the same edge.
- R6: When no response arrives, strobe_o stays high for exactly TIMEOUT_CYCLES cycles. The internal bus error then ends the cycle with vector 24, or with a retry when halt is high.
- R7: A bus error (external or timeout) sampled with halt high gives a retry pulse instead of done. strobe_o is low for that one cycle and is then raised again at the same level, with a fresh timeout count.
- R8: done_o and retry_o are single-cycle pulses that are never high together. strobe_o is low while either is high. vector_o changes only together with a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ack_req | input | 1 | Request to start an acknowledge cycle |
| ack_level | input | 3 | Interrupt level being acknowledged, 1 to 7 |
| dtack_i | input | 1 | Data-strobe acknowledge from the responder |
| avec_i | input | 1 | Autovector request from the responder |
| berr_i | input | 1 | External bus error |
| halt_i | input | 1 | Halt; turns a bus error into a retry |
| data_i | input | 8 | Vector byte on the data bus |
| strobe_o | output | 1 | Address strobe, high while the cycle runs |
| done_o | output | 1 | One-cycle pulse: vector_o is final |
| retry_o | output | 1 | One-cycle pulse: the acknowledge is repeated |
| vector_o | output | 8 | Final vector number, held until the next done |

## Verification
The assertions check on every cycle how one sampled response maps to the next-cycle result. That covers the acknowledged data, 24 plus the level for an autovector, 24 for a bus error and a retry for a bus error with halt. They also check that the timeout count stays below its limit and is cleared while idle, that done and retry are exclusive one-cycle pulses, and that a retry brings the strobe back. Some behaviours appear only in the bench's scenarios: the exact strobe length of a silent cycle, the retry caused by a timeout under halt, the priority when responses collide, the ignored requests, and that vector_o holds its value across retries and idle time.

// File: rtl/intack_pkg.sv
// Shared types and constants for the interrupt acknowledge vector fetch.
// Assumes 8-bit vector numbers and 3-bit interrupt levels.
package intack_pkg;
    localparam int VEC_W = 8;
    localparam int LVL_W = 3;
    localparam logic [VEC_W-1:0] SPURIOUS_VEC = 8'd24;
    localparam logic [VEC_W-1:0] AUTOVEC_BASE = 8'd24;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STROBE  = 2'd1,
        ST_RECOVER = 2'd2
    } fetch_state_t;
endpackage

// File: rtl/intack_timeout.sv
// Bus timeout monitor. Counts cycles while the strobe is high and flags an
// internal bus error in the TIMEOUT_CYCLES-th strobe cycle. Assumes the
// strobe drops (or the cycle ends) on the edge that samples the flag.
module intack_timeout #(
    parameter int TIMEOUT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expired
);
    localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Flag the internal bus error on the last allowed strobe cycle.
    assign expired = active && (cnt == LAST);

    // Count strobe cycles; any idle cycle clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(TIMEOUT_CYCLES));

    // R7
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt == '0));
endmodule

// File: rtl/intack_resolver.sv
// Termination decoder. Combines the sampled responses into one outcome
// with a fixed priority: bus error (external or timeout) first, where halt
// selects a retry, then data-strobe acknowledge, then autovector.
// Assumes it is only consulted while the strobe is high.
module intack_resolver
    import intack_pkg::*;
(
    input  logic             dtack,
    input  logic             avec,
    input  logic             berr_ext,
    input  logic             berr_tmo,
    input  logic             halt,
    input  logic [VEC_W-1:0] data,
    input  logic [LVL_W-1:0] level,
    output logic             term_valid,
    output logic             term_retry,
    output logic [VEC_W-1:0] term_vec
);
    logic bus_err;

    // Pick the outcome and vector of this sampling edge.
    always_comb begin
        bus_err    = berr_ext || berr_tmo;
        term_valid = bus_err || dtack || avec;
        term_retry = bus_err && halt;
        if (bus_err) begin
            term_vec = SPURIOUS_VEC;
        end else if (dtack) begin
            term_vec = data;
        end else if (avec) begin
            term_vec = AUTOVEC_BASE + {{(VEC_W-LVL_W){1'b0}}, level};
        end else begin
            term_vec = SPURIOUS_VEC;
        end
    end
endmodule

// File: rtl/intack_vector_fetch.sv
// Interrupt acknowledge vector fetch controller. Raises the strobe on a
// request, ends the cycle on the first response edge and reports a vector
// or a retry. Assumes the response inputs are already synchronous to clk.
module intack_vector_fetch
    import intack_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_req,
    input  logic [LVL_W-1:0] ack_level,
    input  logic             dtack_i,
    input  logic             avec_i,
    input  logic             berr_i,
    input  logic             halt_i,
    input  logic [VEC_W-1:0] data_i,
    output logic             strobe_o,
    output logic             done_o,
    output logic             retry_o,
    output logic [VEC_W-1:0] vector_o
);
    fetch_state_t     state;
    logic [LVL_W-1:0] lvl_q;
    logic             tmo;
    logic             term_valid;
    logic             term_retry;
    logic [VEC_W-1:0] term_vec;

    // Strobe is high exactly while a bus cycle is open.
    assign strobe_o = (state == ST_STROBE);

    intack_timeout #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timeout (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (strobe_o),
        .expired (tmo)
    );

    intack_resolver u_resolver (
        .dtack      (dtack_i),
        .avec       (avec_i),
        .berr_ext   (berr_i),
        .berr_tmo   (tmo),
        .halt       (halt_i),
        .data       (data_i),
        .level      (lvl_q),
        .term_valid (term_valid),
        .term_retry (term_retry),
        .term_vec   (term_vec)
    );

    // Sequence idle, strobe and recovery, and register the result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lvl_q    <= '0;
            done_o   <= 1'b0;
            retry_o  <= 1'b0;
            vector_o <= '0;
        end else begin
            done_o  <= 1'b0;
            retry_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (ack_req && (ack_level != '0)) begin
                        lvl_q <= ack_level;
                        state <= ST_STROBE;
                    end
                end
                ST_STROBE: begin
                    if (term_valid) begin
                        if (term_retry) begin
                            retry_o <= 1'b1;
                            state   <= ST_RECOVER;
                        end else begin
                            done_o   <= 1'b1;
                            vector_o <= term_vec;
                            state    <= ST_IDLE;
                        end
                    end
                end
                ST_RECOVER: state <= ST_STROBE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // R3
    dtack_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && dtack_i && !berr_i && !tmo)
        |=> (done_o && vector_o == $past(data_i)));

    // R4
    autovec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && avec_i && !dtack_i && !berr_i && !tmo)
        |=> (done_o && vector_o == (AUTOVEC_BASE + {{(VEC_W-LVL_W){1'b0}}, lvl_q})));

    // R5
    berr_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && berr_i && !halt_i) |=> (done_o && vector_o == SPURIOUS_VEC));

    // R7
    berr_halt_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && berr_i && halt_i) |=> (retry_o && !done_o));

    // R7
    retry_restrobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_o |=> strobe_o);

    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && retry_o) && !((done_o || retry_o) && strobe_o));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(vector_o));
endmodule

// File: tb/intack_vector_fetch_bench.sv
module intack_vector_fetch_bench;
    localparam int TMO = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ack_req = 1'b0;
    logic [2:0] ack_level = 3'd0;
    logic       dtack_i = 1'b0;
    logic       avec_i = 1'b0;
    logic       berr_i = 1'b0;
    logic       halt_i = 1'b0;
    logic [7:0] data_i = 8'd0;
    logic       strobe_o, done_o, retry_o;
    logic [7:0] vector_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        bit         is_retry;
        logic [7:0] vec;
        string      tag;
    } exp_t;
    exp_t expq[$];

    always #2 clk = ~clk;

    intack_vector_fetch #(.TIMEOUT_CYCLES(TMO)) u_intack_vector_fetch (
        .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .ack_level(ack_level),
        .dtack_i(dtack_i), .avec_i(avec_i), .berr_i(berr_i), .halt_i(halt_i),
        .data_i(data_i), .strobe_o(strobe_o), .done_o(done_o),
        .retry_o(retry_o), .vector_o(vector_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input bit r, input logic [7:0] v, input string tag);
        exp_t e;
        e.is_retry = r; e.vec = v; e.tag = tag;
        expq.push_back(e);
    endtask

    // Monitor: pops one expected result per done or retry pulse.
    always @(negedge clk) begin
        if (rst_n && (done_o || retry_o)) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R8 unexpected pulse", {done_o, retry_o}, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk(!(done_o && retry_o) && !strobe_o, "R8 exclusive pulse", {done_o, retry_o}, e.is_retry ? 1 : 2);
                if (e.is_retry) begin
                    chk(retry_o && !done_o, e.tag, retry_o, 1);
                end else begin
                    chk(done_o && !retry_o, e.tag, done_o, 1);
                    chk(vector_o == e.vec, e.tag, vector_o, e.vec);
                end
            end
        end
    end

    // Request a cycle and return on the first strobe cycle.
    task automatic start(input logic [2:0] lvl);
        @(negedge clk);
        ack_req = 1'b1; ack_level = lvl;
        @(negedge clk);
        ack_req = 1'b0; ack_level = 3'd0;
        chk(strobe_o, "R2 strobe after request", strobe_o, 1);
    endtask

    // Present responses for one sampling edge.
    task automatic respond(input bit d, input bit a, input bit b, input bit h, input logic [7:0] v);
        dtack_i = d; avec_i = a; berr_i = b; halt_i = h; data_i = v;
        @(negedge clk);
        dtack_i = 0; avec_i = 0; berr_i = 0; halt_i = 0; data_i = 8'hEE;
    endtask

    task automatic wait_strobe();
        while (!strobe_o) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!strobe_o, "R1 strobe", strobe_o, 0);
        chk(!done_o, "R1 done", done_o, 0);
        chk(!retry_o, "R1 retry", retry_o, 0);
        chk(vector_o == 8'd0, "R1 vector", vector_o, 0);

        // R3 plain acknowledge
        start(3'd5);
        push(0, 8'hA7, "R3 dtack vector");
        respond(1, 0, 0, 0, 8'hA7);

        // R3 acknowledge with halt still normal; late response after waits
        start(3'd2);
        repeat (3) @(negedge clk);
        push(0, 8'h41, "R3 dtack with halt");
        respond(1, 0, 0, 1, 8'h41);

        // R4 autovector level 6 -> 30
        start(3'd6);
        push(0, 8'd30, "R4 autovector");
        respond(0, 1, 0, 0, 8'h99);

        // R4 dtack beats avec
        start(3'd1);
        push(0, 8'h5C, "R4 dtack over avec");
        respond(1, 1, 0, 0, 8'h5C);

        // R5 bus error alone, and with dtack on the same edge
        start(3'd4);
        push(0, 8'd24, "R5 berr spurious");
        respond(0, 0, 1, 0, 8'h12);
        start(3'd4);
        push(0, 8'd24, "R5 berr with dtack");
        respond(1, 1, 1, 0, 8'h12);

        // R6 timeout with no response
        start(3'd7);
        push(0, 8'd24, "R6 timeout spurious");
        n = 0;
        while (strobe_o) begin n++; @(negedge clk); end
        chk(n == TMO, "R6 strobe length", n, TMO);

        // R7 berr+halt retry, vector held, then acknowledge
        held = vector_o;
        start(3'd3);
        push(1, 8'd0, "R7 berr halt retry");
        respond(0, 0, 1, 1, 8'h00);
        chk(!strobe_o, "R7 strobe low on retry", strobe_o, 0);
        chk(vector_o == held, "R8 vector held on retry", vector_o, held);
        @(negedge clk);
        chk(strobe_o, "R7 strobe raised again", strobe_o, 1);
        push(0, 8'd27, "R7 retried level kept");
        respond(0, 1, 0, 0, 8'h00);

        // R7 timeout under halt gives retry, fresh count afterwards
        start(3'd2);
        halt_i = 1'b1;
        push(1, 8'd0, "R7 timeout halt retry");
        n = 0;
        while (strobe_o) begin n++; @(negedge clk); end
        chk(n == TMO, "R7 strobe length before retry", n, TMO);
        halt_i = 1'b0;
        wait_strobe();
        push(0, 8'd24, "R7 second timeout spurious");
        n = 0;
        while (strobe_o) begin n++; @(negedge clk); end
        chk(n == TMO, "R7 fresh timeout count", n, TMO);

        // R2 level 0 ignored
        @(negedge clk);
        ack_req = 1'b1; ack_level = 3'd0;
        @(negedge clk);
        ack_req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(!strobe_o, "R2 level zero ignored", strobe_o, 0);
            @(negedge clk);
        end

        // R2 request while busy ignored
        start(3'd3);
        ack_req = 1'b1; ack_level = 3'd6;
        @(negedge clk);
        ack_req = 1'b0; ack_level = 3'd0;
        push(0, 8'd27, "R2 busy request ignored");
        respond(0, 1, 0, 0, 8'h00);
        chk(!strobe_o, "R2 no restart after busy request", strobe_o, 0);

        // R8 vector held while idle
        held = vector_o;
        repeat (4) @(negedge clk);
        chk(vector_o == held, "R8 vector held idle", vector_o, held);

        repeat (3) @(negedge clk);
        chk(expq.size() == 0, "R8 all results seen", expq.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule